// File: doc/BRIEF.md
# Minimum-Depth Parallel Prefix Scan

This block computes the running combination of N words under one associative operator in a single clock cycle. It has the shortest possible logic path: log2(N) operator levels. The network is built by halving. Each half of the input is scanned on its own, in parallel. Then the last result of the lower half is broadcast and combined into every lane of the upper half. The same step repeats inside each half at every level. A lane in the upper part of a block therefore takes its seed from a single node, and the fan-out of that node doubles at each level.

A caller presents N packed words together with a strobe. One cycle later, registered outputs give three results:
- the inclusive scan;
- an optional exclusive scan, which is the inclusive result moved up one lane with the operator's identity placed in lane 0;
- the reduction of all N words.

When the strobe is low the outputs hold their last values. The lane count, word width, operator and the exclusive output are all chosen by parameters.

Top module: `skl_scan_top`

## Requirements
- R1: `out_valid` is low in reset and in the first cycle after it. In each later cycle it equals `in_valid` from one clock earlier.
- R2: One cycle after a strobe, inclusive lane k (bits [k*W +: W]) equals the operator folded serially over input lanes 0 through k, in ascending lane order.
- R3: One cycle after a strobe, `total` equals the fold of all N input lanes, which is also the value of the highest inclusive lane.
- R4: When EXCL_EN is 1, exclusive lane 0 holds the operator identity: all ones for AND and zero for the other operators. Exclusive lane k (k ≥ 1) equals inclusive lane k-1.
- R5: When EXCL_EN is 0, `excl_lanes` is constant zero.
- R6: A cycle with `in_valid` low leaves `incl_lanes`, `excl_lanes` and `total` unchanged, whatever the value on `in_lanes`.
- R7: Addition wraps modulo 2^W, with no saturation and no carry out.
- R8: The OP parameter selects the operator: 0 is add, 1 is XOR, 2 is AND, 3 is OR, 4 is unsigned maximum.
- R9: One cycle after a strobe, inclusive lane 0 equals input lane 0.
- R10: In reset, `incl_lanes`, `total` and `excl_lanes` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: capture a scan of `in_lanes` |
| in_lanes | input | N*W | Input words, lane k at bits [k*W +: W] |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| incl_lanes | output | N*W | Inclusive scan, lane k at bits [k*W +: W] |
| excl_lanes | output | N*W | Exclusive scan, or zero when EXCL_EN is 0 |
| total | output | W | Reduction of all input lanes |

## Verification
The embedded properties assume that `in_valid` is a clean level, sampled once per edge, and that `in_lanes` is steady at any edge where the strobe is high. They make no assumption about the data while the strobe is low. The bench always drives on the falling edge, so both conditions hold. While the strobe is low it deliberately writes unrelated data to `in_lanes`, which exercises the hold rule.

// File: rtl/skl_scan_pkg.sv
package skl_scan_pkg;

   localparam int OP_ADD = 0;
   localparam int OP_XOR = 1;
   localparam int OP_AND = 2;
   localparam int OP_OR  = 3;
   localparam int OP_MAX = 4;
   localparam int OP_LAST = OP_MAX;

   localparam int MAX_WORD = 64;

   // Identity element of each operator, widened to the largest word.
   function automatic logic [MAX_WORD-1:0] op_identity(input int op);
      if (op == OP_AND) return {MAX_WORD{1'b1}};
      return '0;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/skl_op_node.sv
module skl_op_node
   import skl_scan_pkg::*;
#(
   parameter int W  = 8,
   parameter int OP = OP_ADD
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] y
);

   generate
      if (OP == OP_ADD) begin : g_add
         assign y = lo + hi;
      end else if (OP == OP_XOR) begin : g_xor
         assign y = lo ^ hi;
      end else if (OP == OP_AND) begin : g_and
         assign y = lo & hi;
      end else if (OP == OP_OR) begin : g_or
         assign y = lo | hi;
      end else begin : g_max
         assign y = (lo > hi) ? lo : hi;
      end
   endgenerate

endmodule

// File: rtl/skl_level.sv
// One recursion level: blocks of 2^LVL lanes; the top lane of each lower
// half fans out into every lane of the matching upper half.
module skl_level
   import skl_scan_pkg::*;
#(
   parameter int N   = 8,
   parameter int W   = 8,
   parameter int OP  = OP_ADD,
   parameter int LVL = 1
) (
   input  logic [N*W-1:0] d,
   output logic [N*W-1:0] q
);

   localparam int BLK  = 1 << LVL;
   localparam int HALF = BLK >> 1;

   generate
      for (genvar i = 0; i < N; i++) begin : g_lane
         localparam int POS = i % BLK;
         if (POS >= HALF) begin : g_fan
            localparam int SRC = i - POS + HALF - 1;
            skl_op_node #(.W(W), .OP(OP)) u_node (
               .lo (d[SRC*W +: W]),
               .hi (d[i*W +: W]),
               .y  (q[i*W +: W])
            );
         end else begin : g_pass
            assign q[i*W +: W] = d[i*W +: W];
         end
      end
   endgenerate

endmodule

// File: rtl/skl_excl_shift.sv
module skl_excl_shift
   import skl_scan_pkg::*;
#(
   parameter int N  = 8,
   parameter int W  = 8,
   parameter int OP = OP_ADD
) (
   input  logic [N*W-1:0] incl,
   output logic [N*W-1:0] excl
);

   localparam logic [MAX_WORD-1:0] IDENT_WIDE = op_identity(OP);
   localparam logic [W-1:0]        IDENT      = IDENT_WIDE[W-1:0];

   assign excl[W-1:0] = IDENT;

   generate
      for (genvar k = 1; k < N; k++) begin : g_shift
         assign excl[k*W +: W] = incl[(k-1)*W +: W];
      end
   endgenerate

endmodule

// File: rtl/skl_scan_top.sv
module skl_scan_top
   import skl_scan_pkg::*;
#(
   parameter int N       = 8,
   parameter int W       = 8,
   parameter int OP      = OP_ADD,
   parameter bit EXCL_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_lanes,
   output logic           out_valid,
   output logic [N*W-1:0] incl_lanes,
   output logic [N*W-1:0] excl_lanes,
   output logic [W-1:0]   total
);

   localparam int LG = $clog2(N);

   // Elaboration-time parameter checks
   generate
      if (!is_pow2(N) || N < 2 || N > 32) begin : g_bad_n
         $error("skl_scan_top: N must be a power of two in 2..32");
      end
      if (W < 1 || W > MAX_WORD) begin : g_bad_w
         $error("skl_scan_top: W out of range");
      end
      if (OP < 0 || OP > OP_LAST) begin : g_bad_op
         $error("skl_scan_top: unknown operator code");
      end
   endgenerate

   logic [N*W-1:0] stg [0:LG];
   assign stg[0] = in_lanes;

   generate
      for (genvar l = 1; l <= LG; l++) begin : g_lvl
         skl_level #(.N(N), .W(W), .OP(OP), .LVL(l)) u_lvl (
            .d (stg[l-1]),
            .q (stg[l])
         );
      end
   endgenerate

   logic           vld_q;
   logic [N*W-1:0] incl_q;
   logic [W-1:0]   total_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         incl_q  <= '0;
         total_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            incl_q  <= stg[LG];
            total_q <= stg[LG][N*W-1 -: W];
         end
      end
   end

   assign out_valid  = vld_q;
   assign incl_lanes = incl_q;
   assign total      = total_q;

   generate
      if (EXCL_EN) begin : g_excl
         logic [N*W-1:0] excl_d;
         logic [N*W-1:0] excl_q;

         skl_excl_shift #(.N(N), .W(W), .OP(OP)) u_shift (
            .incl (stg[LG]),
            .excl (excl_d)
         );

         always_ff @(posedge clk) begin
            if (!rst_n)        excl_q <= '0;
            else if (in_valid) excl_q <= excl_d;
         end

         assign excl_lanes = excl_q;

         for (genvar k = 1; k < N; k++) begin : g_chk
            // R4: exclusive register lines up with the inclusive register
            a_r4_excl_shift : assert property (@(posedge clk) disable iff (!rst_n)
               out_valid |-> excl_q[k*W +: W] == incl_q[(k-1)*W +: W]);
         end

         a_r6_excl_hold : assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(excl_q));
      end else begin : g_noexcl
         assign excl_lanes = '0;
      end
   endgenerate

   a_r1_valid_rise : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_valid_fall : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(incl_q) && $stable(total_q)));

   a_r9_lane0 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> incl_q[W-1:0] == $past(in_lanes[W-1:0]));

   a_r3_total_top : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> total_q == incl_q[N*W-1 -: W]);

endmodule

// File: tb/sim_skl_scan_top.sv
module sim_skl_scan_top;

   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int a [32];

   // u0: add, 8 lanes x 8 bits, exclusive on
   logic        v0 = 0;
   logic [63:0] d0 = '0;
   logic        ov0;
   logic [63:0] inc0, exc0;
   logic [7:0]  tot0;
   // u1: max, 4 x 6, exclusive off
   logic        v1 = 0;
   logic [23:0] d1 = '0;
   logic        ov1;
   logic [23:0] inc1, exc1;
   logic [5:0]  tot1;
   // u2: xor, 16 x 5
   logic        v2 = 0;
   logic [79:0] d2 = '0;
   logic        ov2;
   logic [79:0] inc2, exc2;
   logic [4:0]  tot2;
   // u3: and, 2 x 4
   logic        v3 = 0;
   logic [7:0]  d3 = '0;
   logic        ov3;
   logic [7:0]  inc3, exc3;
   logic [3:0]  tot3;

   skl_scan_top #(.N(8), .W(8), .OP(0), .EXCL_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_lanes(d0),
      .out_valid(ov0), .incl_lanes(inc0), .excl_lanes(exc0), .total(tot0));
   skl_scan_top #(.N(4), .W(6), .OP(4), .EXCL_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_lanes(d1),
      .out_valid(ov1), .incl_lanes(inc1), .excl_lanes(exc1), .total(tot1));
   skl_scan_top #(.N(16), .W(5), .OP(1), .EXCL_EN(1'b1)) u2 (
      .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_lanes(d2),
      .out_valid(ov2), .incl_lanes(inc2), .excl_lanes(exc2), .total(tot2));
   skl_scan_top #(.N(2), .W(4), .OP(2), .EXCL_EN(1'b1)) u3 (
      .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_lanes(d3),
      .out_valid(ov3), .incl_lanes(inc3), .excl_lanes(exc3), .total(tot3));

   function automatic longint opf(int op, longint x, longint y, int w);
      longint m = (longint'(1) << w) - 1;
      case (op)
         0: return (x + y) & m;
         1: return (x ^ y) & m;
         2: return x & y & m;
         3: return (x | y) & m;
         default: return (x > y) ? x : y;
      endcase
   endfunction

   function automatic longint ident(int op, int w);
      return (op == 2) ? ((longint'(1) << w) - 1) : 0;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Compare all outputs of one instance against a serial fold of a[].
   task automatic check_lanes(string req, int op, int n, int w, bit excl_en,
                              logic [159:0] inc, logic [159:0] exc, longint tot);
      longint acc = 0;
      longint m = (longint'(1) << w) - 1;
      for (int k = 0; k < n; k++) begin
         longint prev = acc;
         acc = (k == 0) ? (longint'(a[k]) & m) : opf(op, acc, longint'(a[k]) & m, w);
         chk(req, $sformatf("incl lane %0d", k), longint'((inc >> (k*w))) & m, acc);
         if (excl_en)
            chk(req, $sformatf("excl lane %0d", k), longint'((exc >> (k*w))) & m,
                (k == 0) ? ident(op, w) : prev);
         else
            chk(req, $sformatf("excl off lane %0d (R5)", k), longint'((exc >> (k*w))) & m, 0);
      end
      chk(req, "total (R3)", tot, acc);
   endtask

   // Pulse the strobe of one instance for one cycle with a[] packed in.
   task automatic apply(int which);
      @(negedge clk);
      case (which)
         0: begin for (int k = 0; k < 8;  k++) d0[k*8 +: 8] = a[k][7:0]; v0 = 1; end
         1: begin for (int k = 0; k < 4;  k++) d1[k*6 +: 6] = a[k][5:0]; v1 = 1; end
         2: begin for (int k = 0; k < 16; k++) d2[k*5 +: 5] = a[k][4:0]; v2 = 1; end
         default: begin for (int k = 0; k < 2; k++) d3[k*4 +: 4] = a[k][3:0]; v3 = 1; end
      endcase
      @(negedge clk);
      v0 = 0; v1 = 0; v2 = 0; v3 = 0;
   endtask

   task automatic t_reset();
      chk("R1", "u0 out_valid in reset", longint'(ov0), 0);
      chk("R10", "u0 incl in reset", longint'(inc0), 0);
      chk("R10", "u0 excl in reset", longint'(exc0), 0);
      chk("R10", "u0 total in reset", longint'(tot0), 0);
      chk("R10", "u2 incl in reset", longint'(inc2 != 0), 0);
   endtask

   task automatic t_add_ramp();
      for (int k = 0; k < 8; k++) a[k] = k + 1;
      apply(0);
      chk("R1", "u0 out_valid after strobe", longint'(ov0), 1);
      chk("R9", "u0 lane0", longint'(inc0[7:0]), 1);
      check_lanes("R2", 0, 8, 8, 1'b1, 160'(inc0), 160'(exc0), longint'(tot0));
      @(negedge clk);
      chk("R1", "u0 out_valid drops", longint'(ov0), 0);
   endtask

   task automatic t_hold();
      // junk on inputs while strobe low; outputs must keep the ramp result
      d0 = 64'hDEAD_BEEF_0123_4567;
      repeat (3) @(negedge clk);
      check_lanes("R6", 0, 8, 8, 1'b1, 160'(inc0), 160'(exc0), longint'(tot0));
   endtask

   task automatic t_add_wrap();
      for (int k = 0; k < 8; k++) a[k] = 8'hFF;
      apply(0);
      chk("R7", "u0 lane1 wraps", longint'(inc0[15:8]), 8'hFE);
      chk("R7", "u0 total wraps", longint'(tot0), 8'hF8);
      check_lanes("R7", 0, 8, 8, 1'b1, 160'(inc0), 160'(exc0), longint'(tot0));
   endtask

   task automatic t_add_random();
      int s = 32'h1357;
      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < 8; k++) begin
            s = s * 1103515245 + 12345;
            a[k] = (s >>> 16) & 8'hFF;
         end
         apply(0);
         check_lanes("R2", 0, 8, 8, 1'b1, 160'(inc0), 160'(exc0), longint'(tot0));
      end
   endtask

   task automatic t_max();
      a[0] = 5; a[1] = 3; a[2] = 63; a[3] = 10;
      apply(1);
      chk("R8", "u1 max lane3", longint'(inc1[23:18]), 63);
      check_lanes("R8", 4, 4, 6, 1'b0, 160'(inc1), 160'(exc1), longint'(tot1));
      chk("R5", "u1 excl zero", longint'(exc1), 0);
   endtask

   task automatic t_xor();
      for (int k = 0; k < 16; k++) a[k] = (k * 7 + 3) & 31;
      apply(2);
      chk("R1", "u2 out_valid", longint'(ov2), 1);
      check_lanes("R8", 1, 16, 5, 1'b1, 160'(inc2), 160'(exc2), longint'(tot2));
      a[0] = 31;
      for (int k = 1; k < 16; k++) a[k] = 0;
      apply(2);
      check_lanes("R2", 1, 16, 5, 1'b1, 160'(inc2), 160'(exc2), longint'(tot2));
   endtask

   task automatic t_and();
      a[0] = 4'hC; a[1] = 4'h6;
      apply(3);
      chk("R4", "u3 excl lane0 identity", longint'(exc3[3:0]), 4'hF);
      chk("R8", "u3 and total", longint'(tot3), 4'h4);
      check_lanes("R4", 2, 2, 4, 1'b1, 160'(inc3), 160'(exc3), longint'(tot3));
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "u0 out_valid first cycle", longint'(ov0), 0);
      t_add_ramp();
      t_hold();
      t_add_wrap();
      t_add_random();
      t_max();
      t_xor();
      t_and();
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule